// File: doc/BRIEF.md
# FPD-Link Pixel Serializer

This block converts parallel 18-bit RGB video, together with a data-enable flag and two active-low sync flags, into the seven-bit-per-pixel serial form used by flat-panel display links. Each pixel is spread over three data lanes. A fourth lane carries a fixed clock pattern that lets the receiver find the pixel boundaries. All four lanes are plain single-ended logic bits. Line drivers sit outside this block.

The block runs on a bit clock at seven times the pixel rate. It raises a one-bit-clock ready strobe in the last bit slot of every pixel. The pixel source must present the next pixel on the inputs during that strobe cycle. The inputs are captured at the clock edge that ends the strobe cycle, and their first bits appear on the lanes in the next cycle. Input values at any other time are ignored. Until the first pixel is captured after reset, the lanes send a blank pixel.

Top module: `rgb_lane_serializer`

## Requirements
- R1: While reset is asserted and until the first pixel capture, `pixel_ready` is low outside its strobe cycles, and the lanes carry a blank pixel: enable 0, both syncs 1, all colour bits 0. In transmit order this gives lane 2 = 0110000, lane 1 = 0000000, lane 0 = 0000000.
- R2: After reset is released, `pixel_ready` is high for exactly one bit clock out of every seven. The first strobe falls in the seventh cycle after release.
- R3: The inputs are captured at the rising edge that ends a `pixel_ready` cycle. Bit slot 0 of the captured pixel appears on all lanes in the next cycle, and the remaining slots follow one per cycle.
- R4: Lane 2 sends, first to last: enable, vertical sync, horizontal sync, blue[5], blue[4], blue[3], blue[2]. Both sync flags are forwarded as given, active-low, with no inversion.
- R5: Lane 1 sends, first to last: blue[1], blue[0], green[5], green[4], green[3], green[2], green[1].
- R6: Lane 0 sends, first to last: green[0], red[5], red[4], red[3], red[2], red[1], red[0].
- R7: The clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6 of every pixel, including the blank pixel.
- R8: Input changes in any cycle where `pixel_ready` is low have no effect on the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit-rate clock, seven periods per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| de_in | input | 1 | Data enable of the offered pixel |
| vsync_n | input | 1 | Vertical sync, active-low |
| hsync_n | input | 1 | Horizontal sync, active-low |
| red | input | 6 | Red component |
| green | input | 6 | Green component |
| blue | input | 6 | Blue component |
| pixel_ready | output | 1 | High in the last slot of each pixel; the next pixel is taken at the end of it |
| lane0 | output | 1 | Serial data lane 0 |
| lane1 | output | 1 | Serial data lane 1 |
| lane2 | output | 1 | Serial data lane 2 |
| lane_clk | output | 1 | Serial clock-pattern lane |

## Verification
The bench builds the block with its default clock pattern and the fixed seven-slot, six-bit-per-colour format. It streams 512 pixels in which every 6-bit code of each colour and all eight combinations of enable and sync flags appear. It then deserializes all four lanes and compares each pixel word with the pixel it offered. Complemented values are driven in every cycle outside the ready strobe, so any capture at the wrong time shows up in the next pixel's words.

// File: rtl/pxser_pkg.sv
// Shared types and constants for the pixel serializer.
// Assumes a fixed seven-slot word per lane and six-bit colour components.
package pxser_pkg;
    localparam int SLOTS   = 7;
    localparam int COLOR_W = 6;
    localparam int LANES   = 4;                 // 0..2 data, 3 clock
    localparam int SLOT_W  = $clog2(SLOTS);

    typedef logic [SLOTS-1:0] word_t;           // MSB is sent first
    typedef logic [LANES-1:0][SLOTS-1:0] lanes_t;

    typedef struct packed {
        logic               de;
        logic               vs_n;
        logic               hs_n;
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
    } pixel_t;

    localparam pixel_t BLANK_PIX = '{de: 1'b0, vs_n: 1'b1, hs_n: 1'b1,
                                     r: '0, g: '0, b: '0};

    // Spread one pixel over the lane words in transmit order.
    function automatic lanes_t map_pixel(pixel_t p, word_t clk_word);
        lanes_t w;
        w[2] = {p.de, p.vs_n, p.hs_n, p.b[5:2]};
        w[1] = {p.b[1:0], p.g[5:1]};
        w[0] = {p.g[0], p.r};
        w[3] = clk_word;
        return w;
    endfunction
endpackage

// File: rtl/pxser_slot_counter.sv
// Bit-slot counter: counts 0 to SLOTS-1 and wraps.
// Flags the last slot, which is when the next pixel is taken.
module pxser_slot_counter #(
    parameter int SLOTS = 7,
    localparam int W = $clog2(SLOTS)
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] slot,
    output logic         last
);
    localparam logic [W-1:0] LAST_SLOT = W'(SLOTS - 1);

    // Advance the slot index and wrap after the final slot.
    always_ff @(posedge clk) begin
        if (!rst_n)           slot <= '0;
        else if (slot == LAST_SLOT) slot <= '0;
        else                  slot <= slot + 1'b1;
    end

    // The last slot flag is decoded from the index.
    always_comb last = (slot == LAST_SLOT);
endmodule

// File: rtl/pxser_lane_shifter.sv
// One lane's shift register: loads a word on request and sends it MSB first.
// Assumes the load happens once every SLOTS cycles, on the last slot.
module pxser_lane_shifter #(
    parameter int SLOTS = 7,
    parameter logic [SLOTS-1:0] RESET_WORD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SLOTS-1:0] load_word,
    output logic             ser_out
);
    logic [SLOTS-1:0] sh_q;

    // Load a fresh word or shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)    sh_q <= RESET_WORD;
        else if (load) sh_q <= load_word;
        else           sh_q <= {sh_q[SLOTS-2:0], 1'b0};
    end

    // The serial output is the current MSB.
    always_comb ser_out = sh_q[SLOTS-1];
endmodule

// File: rtl/rgb_lane_serializer.sv
// Pixel-to-lane serializer top level.
// Takes a pixel at the end of each ready slot and sends it over three data
// lanes and one clock-pattern lane, seven bits per pixel each.
// Assumes bit_clk runs at seven times the pixel rate.
module rgb_lane_serializer #(
    parameter logic [pxser_pkg::SLOTS-1:0] CLK_PATTERN = 7'b1100011
) (
    input  logic       bit_clk,
    input  logic       rst_n,
    input  logic       de_in,
    input  logic       vsync_n,
    input  logic       hsync_n,
    input  logic [5:0] red,
    input  logic [5:0] green,
    input  logic [5:0] blue,
    output logic       pixel_ready,
    output logic       lane0,
    output logic       lane1,
    output logic       lane2,
    output logic       lane_clk
);
    import pxser_pkg::*;

    localparam lanes_t BLANK_WORDS = map_pixel(BLANK_PIX, CLK_PATTERN);

    logic [SLOT_W-1:0] slot;
    logic              last_slot;
    pixel_t            in_pix;
    lanes_t            next_words;
    logic [LANES-1:0]  ser;

    pxser_slot_counter #(.SLOTS(SLOTS)) u_cnt (
        .clk  (bit_clk),
        .rst_n(rst_n),
        .slot (slot),
        .last (last_slot)
    );

    // Gather the port values into one pixel and map it onto lane words.
    always_comb begin
        in_pix     = '{de: de_in, vs_n: vsync_n, hs_n: hsync_n,
                       r: red, g: green, b: blue};
        next_words = map_pixel(in_pix, CLK_PATTERN);
    end

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        pxser_lane_shifter #(
            .SLOTS     (SLOTS),
            .RESET_WORD(BLANK_WORDS[gi])
        ) u_sh (
            .clk      (bit_clk),
            .rst_n    (rst_n),
            .load     (last_slot),
            .load_word(next_words[gi]),
            .ser_out  (ser[gi])
        );
    end

    // Drive the ports from the shifters and the slot decode.
    always_comb begin
        pixel_ready = last_slot;
        lane0       = ser[0];
        lane1       = ser[1];
        lane2       = ser[2];
        lane_clk    = ser[3];
    end

    logic unused_slot;
    always_comb unused_slot = ^slot;
endmodule

// File: rtl/rgb_lane_serializer_chk.sv
// Port-level checker for the serializer, attached by bind.
// Assumes the default clock pattern, which begins and ends with 1.
module rgb_lane_serializer_chk (
    input logic       bit_clk,
    input logic       rst_n,
    input logic       de_in,
    input logic [5:0] green,
    input logic [5:0] blue,
    input logic       pixel_ready,
    input logic       lane0,
    input logic       lane1,
    input logic       lane2,
    input logic       lane_clk
);
    localparam int SLOTS = pxser_pkg::SLOTS;
    localparam int GW    = $clog2(SLOTS + 1);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    // Count the cycles since reset or since the last strobe.
    always_ff @(posedge bit_clk) begin
        if (!rst_n)           gap_q <= '0;
        else if (pixel_ready) gap_q <= '0;
        else if (gap_q != GW'(SLOTS)) gap_q <= gap_q + 1'b1;
    end

    // Record that a pixel has been captured since reset.
    always_ff @(posedge bit_clk) begin
        if (!rst_n)           seen_q <= 1'b0;
        else if (pixel_ready) seen_q <= 1'b1;
    end

    AST_READY_PERIOD: assert property (@(posedge bit_clk) disable iff (!rst_n) (gap_q == GW'(SLOTS-1)) |-> pixel_ready); // R2
    AST_READY_SINGLE: assert property (@(posedge bit_clk) disable iff (!rst_n) pixel_ready |=> !pixel_ready); // R2
    AST_CLK_FIRST: assert property (@(posedge bit_clk) disable iff (!rst_n) pixel_ready |=> lane_clk); // R7
    AST_CLK_LAST: assert property (@(posedge bit_clk) disable iff (!rst_n) pixel_ready |-> lane_clk); // R7
    AST_LANE2_HEAD: assert property (@(posedge bit_clk) disable iff (!rst_n) pixel_ready |=> (lane2 == $past(de_in))); // R4
    AST_LANE1_HEAD: assert property (@(posedge bit_clk) disable iff (!rst_n) pixel_ready |=> (lane1 == $past(blue[1]))); // R5
    AST_LANE0_HEAD: assert property (@(posedge bit_clk) disable iff (!rst_n) pixel_ready |=> (lane0 == $past(green[0]))); // R6
    AST_BLANK_START: assert property (@(posedge bit_clk) disable iff (!rst_n) !seen_q |-> (!lane0 && !lane1)); // R1

    logic unused_bits;
    always_comb unused_bits = ^{green[5:1], blue[5:2], blue[0]};
endmodule

bind rgb_lane_serializer rgb_lane_serializer_chk u_chk (.*);

// File: tb/tb_rgb_lane_serializer.sv
// Streams a sweep of pixels, deserializes the lanes and compares them.
module tb_rgb_lane_serializer;
    logic       bit_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       de_in   = 1'b0;
    logic       vsync_n = 1'b1;
    logic       hsync_n = 1'b1;
    logic [5:0] red = '0, green = '0, blue = '0;
    logic       pixel_ready, lane0, lane1, lane2, lane_clk;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    rgb_lane_serializer dut (.*);

    always #5 bit_clk = ~bit_clk;

    // Expected pixel currently on the lanes.
    logic       e_de = 1'b0, e_v = 1'b1, e_h = 1'b1;
    logic [5:0] e_r = '0, e_g = '0, e_b = '0;
    logic [6:0] got0, got1, got2, gotc;
    int         slot_i;

    task automatic check(input bit ok, input string req,
                         input logic [6:0] act, input logic [6:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Pixel number k of the sweep, from simple arithmetic on k.
    task automatic drive_pixel(input int k);
        red     = 6'(k);
        green   = 6'(k * 5 + 3);
        blue    = 6'(k * 11 + 7);
        de_in   = k[0];
        vsync_n = k[7];
        hsync_n = k[8] ^ k[1];
    endtask

    // Compare the seven collected bits per lane against the expected pixel.
    task automatic check_pixel();
        logic [6:0] x2, x1, x0;
        x2 = {e_de, e_v, e_h, e_b[5], e_b[4], e_b[3], e_b[2]};
        x1 = {e_b[1], e_b[0], e_g[5], e_g[4], e_g[3], e_g[2], e_g[1]};
        x0 = {e_g[0], e_r[5], e_r[4], e_r[3], e_r[2], e_r[1], e_r[0]};
        check(got2 == x2, "R4 lane2 (R3 R8)", got2, x2);
        check(got1 == x1, "R5 lane1 (R3 R8)", got1, x1);
        check(got0 == x0, "R6 lane0 (R3 R8)", got0, x0);
        check(gotc == 7'b1100011, "R7 clock lane", gotc, 7'b1100011);
    endtask

    // One bit slot: sample at the falling edge, then drive inputs.
    task automatic step(inout int k);
        got0 = {got0[5:0], lane0};
        got1 = {got1[5:0], lane1};
        got2 = {got2[5:0], lane2};
        gotc = {gotc[5:0], lane_clk};
        check(pixel_ready == (slot_i == 6), "R2 ready phase",
              7'(pixel_ready), 7'(slot_i == 6));
        if (slot_i == 6) begin
            check_pixel();
            drive_pixel(k);
            e_de = de_in; e_v = vsync_n; e_h = hsync_n;
            e_r = red; e_g = green; e_b = blue;
            k++;
            slot_i = 0;
        end else begin
            // R8: junk outside the ready cycle must not be captured.
            red = ~e_r; green = ~e_g; blue = ~e_b;
            de_in = ~e_de; vsync_n = ~e_v; hsync_n = ~e_h;
            slot_i++;
        end
    endtask

    initial begin
        int k;
        k = 0;
        slot_i = 0;
        repeat (3) @(negedge bit_clk);
        // R1: reset state shows slot 0 of the blank pixel.
        check(pixel_ready == 1'b0, "R1 ready in reset", 7'(pixel_ready), 7'd0);
        check({lane2, lane1, lane0, lane_clk} == 4'b0001, "R1 lanes in reset",
              7'({lane2, lane1, lane0, lane_clk}), 7'b0001);
        red = 6'h2A; green = 6'h15; blue = 6'h3F; de_in = 1'b1;
        @(negedge bit_clk);
        rst_n = 1'b1;
        // First slot after release belongs to the blank pixel (R1).
        step(k);
        while (k < 512 || slot_i != 0) begin
            @(negedge bit_clk);
            step(k);
        end
        repeat (6) begin
            @(negedge bit_clk);
            step(k);
        end
        @(negedge bit_clk);
        step(k);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(10 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule